// File: doc/BRIEF.md
# Indirect Parallel Bus Network Controller Master

This block drives an 8-bit parallel bus to a network controller whose internal space is reached indirectly. Two address lines choose one of four bus registers: a mode register, the high and low bytes of an internal pointer, and a data port. With the auto-increment bit set in the mode register, each access through the data port moves the pointer by one. This lets the block walk a run of consecutive locations after loading the pointer once.

After reset, or when the core asks for a re-initialisation, the block pulses the controller's hardware reset and waits a settling time. It then enables auto-increment, loads the 48-bit station address, and opens socket 0 in raw mode. When that is finished it raises a done flag.

While the controller's interrupt line is low, the block reads the socket 0 pending-size and read-pointer words. If data is pending, it fetches one raw frame from the circular receive buffer. It drops the frame's two-byte length header and streams the payload to the core with start and end markers, under ready/valid flow control. Finally it moves the read pointer past the frame and issues the receive-release command.

Top module: `pbus_netc_master`

## Requirements
- R1: `bus_addr` selects the controller register: 0 = mode, 1 = pointer high byte, 2 = pointer low byte, 3 = data port. Write data is taken by the controller on the rising edge of `bus_wr_n` while `bus_cs_n` is low.
- R2: After `rst_n` is released, `nic_rst_n` is held low for exactly RST_LOW cycles. No bus access starts until at least RESET_CYCLES cycles after it rises. While `nic_rst_n` is low, `init_done` is 0 and `bus_cs_n` is 1.
- R3: Initialisation writes 0x02 to the mode register (bit 1 = auto-increment). It then writes `mac[47:40]` through `mac[7:0]` to 0x0009..0x000E, and 0x04 (raw mode) to 0x0400 followed by the open command 0x01 to 0x0401. After that, `init_done` becomes 1.
- R4: During every access `bus_cs_n` is low, and a strobe is low for at least two cycles. `bus_rd_n` and `bus_wr_n` are never low together. On writes, `bus_doe` is high with the data stable one cycle before `bus_wr_n` falls, and stays that way until after it rises. During reads, `bus_doe` is low.
- R5: With `init_done` high and `nic_irq_n` low, the block reads 0x0426..0x0429 through auto-increment: a big-endian pending size followed by a big-endian read pointer. If the size is zero, it streams nothing and issues no release.
- R6: A frame starts at 0x6000 + (read pointer mod RX_BUF_BYTES) with a big-endian length that counts its own two bytes. The header is not streamed; the next length-2 bytes are. `rx_sof` marks the first payload byte and `rx_eof` the last. A length of 2 streams nothing.
- R7: When a buffer read reaches offset RX_BUF_BYTES-1, the next byte is read from offset 0 (address 0x6000). This applies to both header and payload bytes.
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and the markers hold their values.
- R9: After each frame, the block writes read pointer + length (modulo 2^16, big-endian) to 0x0428..0x0429, then writes 0x40 to 0x0401.
- R10: A one-cycle `init_req` drops `init_done` on the next cycle. The block then repeats the reset pulse, the settling wait and the full initialisation, and raises `init_done` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | One-cycle re-initialisation request |
| init_done | output | 1 | Controller initialised |
| mac | input | 48 | Station address, first byte in bits 47:40 |
| rx_data | output | 8 | Payload byte |
| rx_valid | output | 1 | Payload byte valid |
| rx_ready | input | 1 | Core accepts the byte |
| rx_sof | output | 1 | First byte of frame |
| rx_eof | output | 1 | Last byte of frame |
| bus_addr | output | 2 | Bus register select |
| bus_dout | output | 8 | Write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 8 | Read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| nic_rst_n | output | 1 | Controller hardware reset, active low |
| nic_irq_n | input | 1 | Controller interrupt, active low |

## Verification
The in-RTL properties watch the bus on every cycle: strobe exclusivity, strobes only under chip select, the minimum strobe width, write data set up and held around the strobe, a quiet bus and low done flag during the controller reset, and the stall behaviour of the receive stream. Whether the right values reach the right internal addresses can only be shown by the bench's scenarios. That covers the station address and socket set-up, the pointer write-back and the release command, payload stripping, ring wrap inside the header and inside the payload, the empty-size and empty-payload cases, and re-initialisation. The bench shows these through its behavioural controller model and expected byte queue.

// File: rtl/pbus_netc_master.sv
module pbus_netc_master #(
  parameter int          RESET_CYCLES  = 24000,
  parameter int          RST_LOW       = 16,
  parameter int          STROBE_CYCLES = 2,
  parameter int          RX_BUF_BYTES  = 2048,
  parameter logic [15:0] RX_BASE       = 16'h6000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  output logic        init_done,
  input  logic [47:0] mac,
  output logic [7:0]  rx_data,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic        rx_sof,
  output logic        rx_eof,
  output logic [1:0]  bus_addr,
  output logic [7:0]  bus_dout,
  output logic        bus_doe,
  input  logic [7:0]  bus_din,
  output logic        bus_cs_n,
  output logic        bus_rd_n,
  output logic        bus_wr_n,
  output logic        nic_rst_n,
  input  logic        nic_irq_n
);
  localparam int CW = $clog2((RESET_CYCLES > RST_LOW ? RESET_CYCLES : RST_LOW) + 1);
  localparam int SW = $clog2(STROBE_CYCLES + 1);
  localparam int OW = $clog2(RX_BUF_BYTES);
  localparam logic [1:0]  A_MODE = 2'd0, A_PH = 2'd1, A_PL = 2'd2, A_DATA = 2'd3;
  localparam logic [15:0] MAC_ADR = 16'h0009, SK_MR = 16'h0400, SK_CR = 16'h0401;
  localparam logic [15:0] SK_RSR = 16'h0426, SK_RPT = 16'h0428;

  typedef enum logic [3:0] {
    S_RST, S_WAIT, S_MR, S_AH, S_AL, S_MAC, S_SKT, S_IDLE,
    S_HDR, S_LEN, S_PAY, S_OUT, S_UPD, S_CMD
  } st_t;

  st_t           st, ret;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [15:0]   ptr, sz, rp, len, remain;
  logic [OW-1:0] ofs;
  logic          first, req_q;

  logic          busy;
  logic [1:0]    stg;
  logic [SW-1:0] scnt;
  logic [7:0]    rdat;

  logic          op_on, op_wr;
  logic [1:0]    op_a;
  logic [7:0]    op_d, mac_b;
  logic          op_last, strobe;
  logic [15:0]   hrp, len_full, nrp;

  assign op_last  = busy && stg == 2'd2;
  assign strobe   = busy && stg == 2'd1;
  assign hrp      = {rp[15:8], rdat};
  assign len_full = {len[15:8], rdat};
  assign nrp      = rp + (len < 16'd2 ? 16'd2 : len);

  always_comb begin
    case (idx)
      3'd0:    mac_b = mac[47:40];
      3'd1:    mac_b = mac[39:32];
      3'd2:    mac_b = mac[31:24];
      3'd3:    mac_b = mac[23:16];
      3'd4:    mac_b = mac[15:8];
      default: mac_b = mac[7:0];
    endcase
  end

  always_comb begin
    op_on = 1'b1;
    op_wr = 1'b1;
    op_a  = A_DATA;
    op_d  = 8'h00;
    case (st)
      S_MR:  begin op_a = A_MODE; op_d = 8'h02; end
      S_AH:  begin op_a = A_PH;   op_d = ptr[15:8]; end
      S_AL:  begin op_a = A_PL;   op_d = ptr[7:0]; end
      S_MAC: op_d = mac_b;
      S_SKT: op_d = (idx == 3'd0) ? 8'h04 : 8'h01;
      S_HDR, S_LEN, S_PAY: op_wr = 1'b0;
      S_UPD: op_d = (idx == 3'd0) ? nrp[15:8] : nrp[7:0];
      S_CMD: op_d = 8'h40;
      default: op_on = 1'b0;
    endcase
  end

  assign bus_cs_n  = !busy;
  assign bus_addr  = op_a;
  assign bus_dout  = op_d;
  assign bus_doe   = busy && op_wr;
  assign bus_wr_n  = !(strobe && op_wr);
  assign bus_rd_n  = !(strobe && !op_wr);
  assign nic_rst_n = (st != S_RST);

  assign rx_data  = rdat;
  assign rx_valid = (st == S_OUT);
  assign rx_sof   = rx_valid && first;
  assign rx_eof   = rx_valid && remain == 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      stg  <= 2'd0;
      scnt <= '0;
      rdat <= 8'h00;
    end else if (!busy) begin
      if (op_on) begin
        busy <= 1'b1;
        stg  <= 2'd0;
      end
    end else begin
      case (stg)
        2'd0: begin stg <= 2'd1; scnt <= '0; end
        2'd1: begin
          if (scnt == SW'(STROBE_CYCLES - 1)) begin
            stg <= 2'd2;
            if (!op_wr) rdat <= bus_din;
          end else begin
            scnt <= scnt + 1'b1;
          end
        end
        default: busy <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RST; ret <= S_IDLE; cnt <= '0; idx <= '0;
      ptr <= '0; sz <= '0; rp <= '0; len <= '0; remain <= '0;
      ofs <= '0; first <= 1'b0; req_q <= 1'b0; init_done <= 1'b0;
    end else begin
      case (st)
        S_RST: begin
          if (cnt == CW'(RST_LOW - 1)) begin st <= S_WAIT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        S_WAIT: begin
          if (cnt == CW'(RESET_CYCLES - 1)) st <= S_MR;
          else cnt <= cnt + 1'b1;
        end
        S_MR: if (op_last) begin ptr <= MAC_ADR; ret <= S_MAC; idx <= '0; st <= S_AH; end
        S_AH: if (op_last) st <= S_AL;
        S_AL: if (op_last) st <= ret;
        S_MAC: if (op_last) begin
          if (idx == 3'd5) begin idx <= '0; ptr <= SK_MR; ret <= S_SKT; st <= S_AH; end
          else idx <= idx + 1'b1;
        end
        S_SKT: if (op_last) begin
          if (idx == 3'd1) begin st <= S_IDLE; init_done <= 1'b1; end
          else idx <= idx + 1'b1;
        end
        S_IDLE: begin
          if (req_q) begin
            st <= S_RST; cnt <= '0; req_q <= 1'b0;
          end else if (!nic_irq_n) begin
            ptr <= SK_RSR; ret <= S_HDR; idx <= '0; st <= S_AH;
          end
        end
        S_HDR: if (op_last) begin
          case (idx)
            3'd0: sz[15:8] <= rdat;
            3'd1: sz[7:0]  <= rdat;
            3'd2: rp[15:8] <= rdat;
            default: rp[7:0] <= rdat;
          endcase
          if (idx == 3'd3) begin
            idx <= '0;
            if (sz == 16'd0) st <= S_IDLE;
            else begin
              ofs <= hrp[OW-1:0];
              ptr <= RX_BASE + 16'(hrp[OW-1:0]);
              ret <= S_LEN;
              st  <= S_AH;
            end
          end else idx <= idx + 1'b1;
        end
        S_LEN: if (op_last) begin
          ofs <= ofs + 1'b1;
          if (idx == 3'd0) begin
            len[15:8] <= rdat;
            idx <= 3'd1;
            if (&ofs) begin ptr <= RX_BASE; ret <= S_LEN; st <= S_AH; end
          end else begin
            len[7:0] <= rdat;
            remain   <= len_full - 16'd2;
            first    <= 1'b1;
            idx      <= '0;
            if (len_full <= 16'd2) begin ptr <= SK_RPT; ret <= S_UPD; st <= S_AH; end
            else if (&ofs) begin ptr <= RX_BASE; ret <= S_PAY; st <= S_AH; end
            else st <= S_PAY;
          end
        end
        S_PAY: if (op_last) begin ofs <= ofs + 1'b1; st <= S_OUT; end
        S_OUT: if (rx_ready) begin
          first  <= 1'b0;
          remain <= remain - 1'b1;
          if (remain == 16'd1) begin ptr <= SK_RPT; ret <= S_UPD; idx <= '0; st <= S_AH; end
          else if (ofs == '0) begin ptr <= RX_BASE; ret <= S_PAY; st <= S_AH; end
          else st <= S_PAY;
        end
        S_UPD: if (op_last) begin
          if (idx == 3'd1) begin idx <= '0; ptr <= SK_CR; ret <= S_CMD; st <= S_AH; end
          else idx <= idx + 1'b1;
        end
        S_CMD: if (op_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (init_req) begin
        req_q     <= 1'b1;
        init_done <= 1'b0;
      end
    end
  end

  // R4
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));
  // R4
  strobe_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n);
  // R4
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $past(bus_doe) && $stable(bus_dout));
  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> bus_doe && !bus_cs_n && $stable(bus_dout));
  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> !$past(bus_wr_n, 2));
  // R4
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> !$past(bus_rd_n, 2));
  // R4
  rd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_doe);
  // R2
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nic_rst_n |-> bus_cs_n && !init_done);
  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_sof) && $stable(rx_eof));
  // R6
  marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sof || rx_eof) |-> rx_valid);
endmodule

// File: tb/sim_pbus_netc_master.sv
module sim_pbus_netc_master;
  localparam int CLK_NS = 10;
  localparam int RSTC   = 40;
  localparam int RLOW   = 4;
  localparam int BUFB   = 64;

  logic clk = 1'b0, rst_n = 1'b0, init_req = 1'b0, rx_ready = 1'b1, nic_irq_n = 1'b1;
  logic [47:0] mac = 48'h02A1_B2C3_D4E5;
  logic [7:0]  din = 8'h00;
  logic init_done, rx_valid, rx_sof, rx_eof, bus_doe, bus_cs_n, bus_rd_n, bus_wr_n, nic_rst_n;
  logic [7:0] rx_data, bus_dout;
  logic [1:0] bus_addr;

  always #(CLK_NS/2) clk = ~clk;

  pbus_netc_master #(.RESET_CYCLES(RSTC), .RST_LOW(RLOW), .STROBE_CYCLES(2),
                     .RX_BUF_BYTES(BUFB), .RX_BASE(16'h6000)) u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .init_done(init_done), .mac(mac),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .nic_rst_n(nic_rst_n), .nic_irq_n(nic_irq_n));

  int cmp = 0, bad = 0, cyc = 0, recv_cnt = 0, opened = 0;
  int wr_run = 0, rd_run = 0, rl_run = 0, gap = -1;
  bit fin = 0, bp = 0, irq_force = 0;
  logic [7:0]  mem [int];
  logic [7:0]  mr = 8'h00;
  logic [15:0] ptr = 16'h0000;
  logic        prev_wr = 1'b1, prev_rd = 1'b1;
  logic [9:0]  exp_q [$];

  function automatic logic [7:0] rdmem(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    cmp++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit rdy;
    logic [9:0] e;
    cyc++;
    if (!nic_rst_n) begin mr = 8'h00; ptr = 16'h0000; end
    if (!bus_cs_n && !bus_rd_n) begin
      case (bus_addr)
        2'd0: din = mr;
        2'd1: din = ptr[15:8];
        2'd2: din = ptr[7:0];
        default: din = rdmem(int'(ptr));
      endcase
    end
    if (!bus_cs_n && !prev_wr && bus_wr_n) begin
      case (bus_addr)
        2'd0: mr = bus_dout;
        2'd1: ptr[15:8] = bus_dout;
        2'd2: ptr[7:0] = bus_dout;
        default: begin
          mem[int'(ptr)] = bus_dout;
          if (ptr == 16'h0401 && bus_dout == 8'h40) begin
            recv_cnt++; mem[32'h426] = 8'h00; mem[32'h427] = 8'h00;
          end
          if (ptr == 16'h0401 && bus_dout == 8'h01) opened = 1;
          if (mr[1]) ptr = ptr + 16'd1;
        end
      endcase
    end
    if (!bus_cs_n && !prev_rd && bus_rd_n && bus_addr == 2'd3 && mr[1]) ptr = ptr + 16'd1;
    // R4 per-cycle bus protocol
    if (rst_n) begin
      chk(!((!bus_rd_n || !bus_wr_n) && bus_cs_n) && !(!bus_rd_n && !bus_wr_n), "R4 strobe/cs",
          {bus_cs_n, bus_rd_n, bus_wr_n}, 3'b011);
      if (!prev_wr && bus_wr_n) chk(wr_run >= 2, "R4 wr width", wr_run, 2);
      if (!prev_rd && bus_rd_n) chk(rd_run >= 2, "R4 rd width", rd_run, 2);
      if (!bus_wr_n) chk(bus_doe, "R4 write data enable", bus_doe, 1);
      if (!bus_rd_n) chk(!bus_doe, "R4 read no drive", bus_doe, 0);
    end
    wr_run = bus_wr_n ? 0 : wr_run + 1;
    rd_run = bus_rd_n ? 0 : rd_run + 1;
    prev_wr = bus_wr_n; prev_rd = bus_rd_n;
    // R2 reset pulse width and settling gap
    if (rst_n && !nic_rst_n) rl_run++;
    else if (rst_n && rl_run > 0) begin
      chk(rl_run == RLOW, "R2 reset pulse", rl_run, RLOW);
      rl_run = 0; gap = 0;
    end
    if (gap >= 0) begin
      if (!bus_cs_n) begin chk(gap >= RSTC, "R2 settle wait", gap, RSTC); gap = -1; end
      else gap++;
    end
    nic_irq_n = irq_force ? 1'b0 : ({rdmem(32'h426), rdmem(32'h427)} == 16'h0000);
    rdy = bp ? (cyc % 3 != 1) : 1'b1;
    rx_ready = rdy;
    if (rst_n && rx_valid && rdy) begin
      if (exp_q.size() == 0) chk(0, "R6 unexpected byte", rx_data, 0);
      else begin
        e = exp_q.pop_front();
        chk(rx_data == e[7:0], "R6/R7 payload byte", rx_data, e[7:0]);
        chk(rx_sof == e[9] && rx_eof == e[8], "R6 sof/eof", {rx_sof, rx_eof}, e[9:8]);
      end
    end
  end

  task automatic frame(input int rp, input int plen, input int seed, input string req);
    int len, r0, nrp;
    logic [7:0] b;
    len = plen + 2; r0 = recv_cnt; nrp = (rp + len) & 16'hFFFF;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      b = (i == 0) ? 8'(len >> 8) : (i == 1) ? 8'(len) : 8'(seed + i * 7);
      mem[32'h6000 + ((rp + i) % BUFB)] = b;
      if (i >= 2) exp_q.push_back({(i == 2), (i == len - 1), b});
    end
    mem[32'h428] = 8'(rp >> 8); mem[32'h429] = 8'(rp);
    mem[32'h427] = 8'(len);     mem[32'h426] = 8'(len >> 8);
    while (recv_cnt == r0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    // R9 pointer write-back and release
    chk({rdmem(32'h428), rdmem(32'h429)} == 16'(nrp), "R9 read pointer",
        {rdmem(32'h428), rdmem(32'h429)}, nrp);
    chk(recv_cnt == r0 + 1 && nic_irq_n, "R9 release", recv_cnt - r0, 1);
  endtask

  initial begin
    int r0;
    logic [15:0] sv;
    repeat (3) @(negedge clk);
    chk(!init_done && !nic_rst_n && bus_cs_n && !rx_valid, "R2 reset state",
        {init_done, nic_rst_n, bus_cs_n, rx_valid}, 4'b0010);
    rst_n = 1'b1;
    while (!init_done) @(negedge clk);
    chk(mr == 8'h02, "R3 mode auto-increment", mr, 8'h02);
    for (int i = 0; i < 6; i++)
      chk(rdmem(9 + i) == 8'(mac >> (40 - 8 * i)), "R3 station address", rdmem(9 + i),
          8'(mac >> (40 - 8 * i)));
    chk(rdmem(32'h400) == 8'h04 && opened == 1, "R3 socket raw open", rdmem(32'h400), 8'h04);
    chk(ptr == 16'h0402, "R1 pointer bytes and data port", ptr, 16'h0402);
    frame(0, 5, 8'h11, "R6 basic frame");
    bp = 1;
    frame(7, 20, 8'h30, "R8 stalled stream");
    bp = 0;
    frame(55, 12, 8'h50, "R7 payload wrap");
    frame(16'h00FF, 3, 8'h70, "R7 header wrap");
    frame(16'h0104, 0, 8'h00, "R6 empty payload");
    // R5 zero pending size: no stream, no release
    r0 = recv_cnt; sv = {rdmem(32'h428), rdmem(32'h429)};
    irq_force = 1;
    repeat (120) @(negedge clk);
    irq_force = 0;
    repeat (30) @(negedge clk);
    chk(recv_cnt == r0, "R5 zero size no release", recv_cnt - r0, 0);
    chk({rdmem(32'h428), rdmem(32'h429)} == sv, "R5 pointer untouched",
        {rdmem(32'h428), rdmem(32'h429)}, sv);
    // R10 re-initialisation
    opened = 0; mem[9] = 8'h00;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
    chk(!init_done, "R10 done cleared", init_done, 0);
    @(negedge clk);
    while (!init_done) @(negedge clk);
    chk(rdmem(9) == mac[47:40] && opened == 1, "R10 init repeated", rdmem(9), mac[47:40]);
    frame(16'h0106, 4, 8'h90, "R10 receive after reinit");
    if (!fin) begin
      fin = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!fin) begin
      fin = 1;
      cmp++; bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
      $finish;
    end
  end
endmodule